// File: doc/BRIEF.md
# Double-Buffered Clock Register Window

This block places eight clock registers at the top eight byte addresses of a 2K byte bus space (0x7F8 to 0x7FF) and routes every lower address to an ordinary RAM port. Time is held twice. A set of running counters, which live outside this block, keeps advancing. A holding set, which is what the bus sees, is normally refreshed from those counters on each one-second tick. Every field is copied in a single clock edge, so a read never returns a mix of old and new fields.

Two control bits in the control/century register change this. The freeze-for-read bit stops refreshes of the holding set while the counters keep running. The freeze-for-set bit also stops refreshes. Clearing it sends a one-cycle load pulse to the counters, together with the holding values that software wrote. After both bits return to 0, ticks are ignored until the bits have stayed low for a parameterised number of cycles. This count stands for the minimum low time the refresh path needs.

The oscillator-stop bit and the frequency-test bit are plain read/write bits, and each is brought out as a level. The battery-good flag is a read-only input shown in the day register.

Top module: `rtc_holding_window`

## Requirements
- R1: With `bus_sel` high, an address below 0x7F8 asserts `ram_sel`, asserts `ram_we` when `bus_we` is high, and returns `ram_rdata` on `bus_rdata`. An address from 0x7F8 to 0x7FF never asserts `ram_sel` or `ram_we`.
- R2: The window offsets 0 to 7 hold, in this order: control/century, seconds, minutes, hours, day of week, date, month and year. Byte k of `cnt_vals` and of `load_vals` belongs to offset k.
- R3: At offset 0, bit 7 is the freeze-for-set bit, bit 6 is the freeze-for-read bit, and bits 5:0 are the century. All three read back as written.
- R4: When both freeze bits are 0 and have settled, a cycle with `tick_sec` high copies every counter field into the holding set at that edge. The new values are readable in the next cycle.
- R5: While the freeze-for-read bit is 1, ticks leave the holding set unchanged.
- R6: While the freeze-for-set bit is 1, ticks leave the holding set unchanged. A write to offset 0 with bit 7 = 0 while that bit is 1 gives `load_pulse` high for exactly the next cycle, with `load_vals` equal to the holding values. The same write with the bit already 0 gives no pulse.
- R7: After both freeze bits become 0, ticks are ignored until SETTLE_CYCLES clock edges have passed with both bits 0.
- R8: Bit 7 of the day register (offset 4) always reads `batt_ok`. Bus writes to that bit have no effect.
- R9: Bit 7 of seconds (offset 1) is the oscillator-stop bit and bit 6 of day (offset 4) is the frequency-test bit. Both are read/write, are driven on `osc_stop` and `freq_test`, and are never changed by a refresh.
- R10: The field widths are: century 6 bits, seconds 7 bits, minutes 7 bits, hours 6 bits, day 3 bits, date 6 bits, month 5 bits, year 8 bits. All other bits read 0, and writes or counter values on those bits are discarded.
- R11: After reset, every holding field, both freeze bits, `osc_stop`, `freq_test` and `load_pulse` are 0, and a tick refreshes at once without waiting to settle.
- R12: A bus write to a clock register takes effect at the next edge. When it lands in the same cycle as a refresh, the written value wins for that register and the other registers still refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| ram_sel | output | 1 | RAM select for addresses below the window |
| ram_we | output | 1 | RAM write strobe |
| ram_rdata | input | 8 | Data returned by the RAM |
| tick_sec | input | 1 | One-cycle pulse per second from the counters |
| cnt_vals | input | 64 | Running counter fields, byte k for offset k |
| batt_ok | input | 1 | Battery-good flag |
| load_pulse | output | 1 | One-cycle counter load strobe |
| load_vals | output | 64 | Holding fields for loading the counters, byte k for offset k |
| osc_stop | output | 1 | Oscillator-stop control level |
| freq_test | output | 1 | Frequency-test control level |

## Verification
The hardest situation to reach from the ports is a tick that arrives inside the settling window after a freeze bit was cleared. The stimulus clears the freeze-for-read bit and pulses `tick_sec` on the very next cycle, so the tick is ignored. It then waits longer than the settle count and ticks again to see the refresh. A second hard case is a bus write that lands on the same edge as a refresh. The stimulus raises `tick_sec` together with a seconds write and then reads both the written register and a register that was only refreshed. The behavioural model follows the settle count on its own and is compared on every clock.

// File: rtl/rtcw_pkg.sv
package rtcw_pkg;
   localparam int NREG    = 8;
   localparam int OFF_W   = 3;
   localparam int BYTE_W  = 8;
   localparam int VALS_W  = NREG * BYTE_W;

   localparam logic [OFF_W-1:0] OFF_CTRL = 3'd0;
   localparam logic [OFF_W-1:0] OFF_SEC  = 3'd1;
   localparam logic [OFF_W-1:0] OFF_DAY  = 3'd4;

   // valid time-field bits of each window register
   function automatic logic [BYTE_W-1:0] field_mask(input int off);
      case (off)
         0:       return 8'h3F;
         1, 2:    return 8'h7F;
         3, 5:    return 8'h3F;
         4:       return 8'h07;
         6:       return 8'h1F;
         default: return 8'hFF;
      endcase
   endfunction
endpackage

// File: rtl/rtcw_decode.sv
module rtcw_decode
   import rtcw_pkg::*;
#(
   parameter int ADDR_W = 11
) (
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   output logic              win_hit,
   output logic              win_wr,
   output logic [OFF_W-1:0]  win_off,
   output logic              ram_sel,
   output logic              ram_we
);
   logic top_block;

   assign top_block = &bus_addr[ADDR_W-1:OFF_W];
   assign win_hit   = bus_sel && top_block;
   assign win_wr    = win_hit && bus_we;
   assign win_off   = bus_addr[OFF_W-1:0];
   assign ram_sel   = bus_sel && !top_block;
   assign ram_we    = ram_sel && bus_we;
endmodule

// File: rtl/rtcw_settle.sv
module rtcw_settle #(
   parameter int SETTLE_CYCLES = 62500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   output logic settled
);
   generate
      if (SETTLE_CYCLES == 0) begin : g_none
         logic unused_in;
         assign unused_in = clk ^ rst_n ^ halt;
         assign settled   = 1'b1;
      end else begin : g_count
         localparam int CW = $clog2(SETTLE_CYCLES + 1);
         localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYCLES);
         logic [CW-1:0] quiet;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              quiet <= LIMIT;
            else if (halt)           quiet <= '0;
            else if (quiet != LIMIT) quiet <= quiet + 1'b1;
         end
         assign settled = (quiet == LIMIT);
      end
   endgenerate
endmodule

// File: rtl/rtcw_holdbank.sv
module rtcw_holdbank
   import rtcw_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              refresh,
   input  logic [VALS_W-1:0] cnt_vals,
   input  logic              wr_en,
   input  logic [OFF_W-1:0]  wr_off,
   input  logic [BYTE_W-1:0] wr_data,
   output logic [VALS_W-1:0] hold_flat
);
   genvar i;
   generate
      for (i = 0; i < NREG; i++) begin : g_reg
         localparam logic [BYTE_W-1:0] MSK = field_mask(i);
         logic [BYTE_W-1:0] q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (wr_en && wr_off == OFF_W'(i))
               q <= wr_data & MSK;
            else if (refresh)
               q <= cnt_vals[i*BYTE_W +: BYTE_W] & MSK;
         end
         assign hold_flat[i*BYTE_W +: BYTE_W] = q;
      end
   endgenerate
endmodule

// File: rtl/rtc_holding_window.sv
module rtc_holding_window
   import rtcw_pkg::*;
#(
   parameter int ADDR_W        = 11,
   parameter int SETTLE_CYCLES = 62500
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   output logic              ram_sel,
   output logic              ram_we,
   input  logic [7:0]        ram_rdata,
   input  logic              tick_sec,
   input  logic [63:0]       cnt_vals,
   input  logic              batt_ok,
   output logic              load_pulse,
   output logic [63:0]       load_vals,
   output logic              osc_stop,
   output logic              freq_test
);
   generate
      if (ADDR_W < OFF_W + 1 || ADDR_W > 24) begin : g_bad_addr_w
         $error("ADDR_W must lie in 4..24");
      end
      if (SETTLE_CYCLES < 0) begin : g_bad_settle
         $error("SETTLE_CYCLES must not be negative");
      end
      if (VALS_W != 64) begin : g_bad_vals
         $error("register window must be eight bytes");
      end
   endgenerate

   logic             win_hit, win_wr;
   logic [OFF_W-1:0] win_off;
   logic             wr_q, rd_q, osc_q, ft_q, load_q;
   logic             settled, halt, refresh, ctrl_wr;
   logic [VALS_W-1:0] hold_flat;
   logic [7:0]       hold_byte, win_rdata;

   rtcw_decode #(.ADDR_W(ADDR_W)) u_dec (
      .bus_sel (bus_sel),
      .bus_we  (bus_we),
      .bus_addr(bus_addr),
      .win_hit (win_hit),
      .win_wr  (win_wr),
      .win_off (win_off),
      .ram_sel (ram_sel),
      .ram_we  (ram_we)
   );

   assign halt    = wr_q || rd_q;
   assign refresh = tick_sec && !halt && settled;
   assign ctrl_wr = win_wr && (win_off == OFF_CTRL);

   rtcw_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt   (halt),
      .settled(settled)
   );

   rtcw_holdbank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .refresh  (refresh),
      .cnt_vals (cnt_vals),
      .wr_en    (win_wr),
      .wr_off   (win_off),
      .wr_data  (bus_wdata),
      .hold_flat(hold_flat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q   <= 1'b0;
         rd_q   <= 1'b0;
         osc_q  <= 1'b0;
         ft_q   <= 1'b0;
         load_q <= 1'b0;
      end else begin
         load_q <= ctrl_wr && wr_q && !bus_wdata[7];
         if (ctrl_wr) begin
            wr_q <= bus_wdata[7];
            rd_q <= bus_wdata[6];
         end
         if (win_wr && win_off == OFF_SEC) osc_q <= bus_wdata[7];
         if (win_wr && win_off == OFF_DAY) ft_q  <= bus_wdata[6];
      end
   end

   assign hold_byte = hold_flat[{win_off, 3'b000} +: 8];

   always_comb begin
      case (win_off)
         OFF_CTRL: win_rdata = {wr_q, rd_q, hold_byte[5:0]};
         OFF_SEC:  win_rdata = {osc_q, hold_byte[6:0]};
         OFF_DAY:  win_rdata = {batt_ok, ft_q, hold_byte[5:0]};
         default:  win_rdata = hold_byte;
      endcase
   end

   assign bus_rdata  = win_hit ? win_rdata : (ram_sel ? ram_rdata : 8'h00);
   assign load_pulse = load_q;
   assign load_vals  = hold_flat;
   assign osc_stop   = osc_q;
   assign freq_test  = ft_q;
endmodule

// File: rtl/rtcw_check.sv
module rtcw_check #(
   parameter int ADDR_W = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_sel,
   input logic              bus_we,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [7:0]        bus_rdata,
   input logic              ram_sel,
   input logic              batt_ok,
   input logic              load_pulse,
   input logic [63:0]       load_vals,
   input logic              wr_q,
   input logic              rd_q
);
   logic in_win, win_write;
   assign in_win    = bus_sel && (&bus_addr[ADDR_W-1:3]);
   assign win_write = in_win && bus_we;

   AST_WINDOW_NOT_RAM: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> !ram_sel); // R1
   AST_BATT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !bus_we && bus_addr[2:0] == 3'd4) |-> bus_rdata[7] == batt_ok); // R8
   AST_FROZEN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rd_q) && !$past(win_write)) |-> $stable(load_vals)); // R5
   AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |-> ($past(wr_q) && !wr_q)); // R6
   AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      load_pulse |=> !load_pulse); // R6
   AST_MONTH_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
      (in_win && !bus_we && bus_addr[2:0] == 3'd6) |-> bus_rdata[7:5] == 3'b000); // R10
endmodule

bind rtc_holding_window rtcw_check #(.ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_rdata (bus_rdata),
   .ram_sel   (ram_sel),
   .batt_ok   (batt_ok),
   .load_pulse(load_pulse),
   .load_vals (load_vals),
   .wr_q      (wr_q),
   .rd_q      (rd_q)
);

// File: tb/rtc_holding_window_test.sv
`timescale 1ns/1ps
module rtc_holding_window_test;
   localparam int AW = 11;
   localparam int S  = 16;
   localparam logic [AW-1:0] BASE = 11'h7F8;

   logic clk = 0, rst_n = 0;
   logic bus_sel = 0, bus_we = 0, tick_sec = 0, batt_ok = 1;
   logic [AW-1:0] bus_addr = '0;
   logic [7:0] bus_wdata = 0, ram_rdata = 0, bus_rdata;
   logic [63:0] cnt_vals = 0, load_vals;
   logic ram_sel, ram_we, load_pulse, osc_stop, freq_test;

   int vectors = 0, miscompares = 0;

   // behavioural reference state
   int m_hold[8];
   bit m_wr, m_rd, m_osc, m_ft, m_lp;
   int m_quiet;
   bit mv_win, mv_wrt, mv_ref, mv_oldhalt;
   int mv_off;

   always #4 clk = ~clk;

   rtc_holding_window #(.ADDR_W(AW), .SETTLE_CYCLES(S)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ram_sel(ram_sel), .ram_we(ram_we), .ram_rdata(ram_rdata),
      .tick_sec(tick_sec), .cnt_vals(cnt_vals), .batt_ok(batt_ok),
      .load_pulse(load_pulse), .load_vals(load_vals),
      .osc_stop(osc_stop), .freq_test(freq_test));

   function automatic int fmask(int i);
      case (i)
         0: return 'h3F; 1: return 'h7F; 2: return 'h7F; 3: return 'h3F;
         4: return 'h07; 5: return 'h3F; 6: return 'h1F; default: return 'hFF;
      endcase
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) m_hold[i] = 0;
      m_wr = 0; m_rd = 0; m_osc = 0; m_ft = 0; m_lp = 0; m_quiet = S;
   endtask

   initial model_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) model_reset();
      else begin
         mv_win = bus_sel && bus_addr >= BASE;
         mv_wrt = mv_win && bus_we;
         mv_off = bus_addr - BASE;
         mv_oldhalt = m_wr || m_rd;
         mv_ref = tick_sec && !mv_oldhalt && m_quiet >= S;
         m_lp = mv_wrt && mv_off == 0 && m_wr && !bus_wdata[7];
         if (mv_ref)
            for (int i = 0; i < 8; i++) m_hold[i] = int'(cnt_vals[8*i +: 8]) & fmask(i);
         if (mv_wrt) begin
            m_hold[mv_off] = int'(bus_wdata) & fmask(mv_off);
            if (mv_off == 0) begin m_wr = bus_wdata[7]; m_rd = bus_wdata[6]; end
            if (mv_off == 1) m_osc = bus_wdata[7];
            if (mv_off == 4) m_ft = bus_wdata[6];
         end
         if (mv_oldhalt) m_quiet = 0;
         else if (m_quiet < S) m_quiet++;
      end
   end

   function automatic logic [7:0] exp_rdata();
      int off;
      if (!bus_sel) return 8'h00;
      if (bus_addr < BASE) return ram_rdata;
      off = bus_addr - BASE;
      case (off)
         0: return {m_wr, m_rd, 6'(m_hold[0])};
         1: return {m_osc, 7'(m_hold[1])};
         4: return {batt_ok, m_ft, 6'(m_hold[4])};
         default: return 8'(m_hold[off]);
      endcase
   endfunction

   function automatic logic [63:0] exp_vals();
      logic [63:0] v;
      for (int i = 0; i < 8; i++) v[8*i +: 8] = 8'(m_hold[i]);
      return v;
   endfunction

   function automatic string rd_tag();
      if (!bus_sel || bus_addr < BASE) return "R1";
      case (bus_addr - BASE)
         0: return "R3";
         1: return "R9";
         4: return "R8";
         default: return "R4";
      endcase
   endfunction

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk(rd_tag(), 64'(bus_rdata), 64'(exp_rdata()));
      chk("R1", {62'd0, ram_sel, ram_we},
          {62'd0, bus_sel && bus_addr < BASE, bus_sel && bus_we && bus_addr < BASE});
      chk("R6", 64'(load_pulse), 64'(m_lp));
      chk("R5", load_vals, exp_vals());
      chk("R9", {62'd0, osc_stop, freq_test}, {62'd0, m_osc, m_ft});
   endtask

   task automatic cyc();
      @(posedge clk); #2;
      compare_all();
   endtask

   task automatic idle(int n);
      bus_sel = 0; bus_we = 0;
      for (int k = 0; k < n; k++) cyc();
   endtask

   task automatic wreg(int off, logic [7:0] d);
      bus_sel = 1; bus_we = 1; bus_addr = BASE + AW'(off); bus_wdata = d;
      cyc();
      bus_sel = 0; bus_we = 0;
   endtask

   task automatic rreg(int off, string tag, logic [7:0] exp);
      bus_sel = 1; bus_we = 0; bus_addr = BASE + AW'(off);
      #1;
      chk(tag, 64'(bus_rdata), 64'(exp));
   endtask

   task automatic tick();
      tick_sec = 1; cyc(); tick_sec = 0;
   endtask

   function automatic logic [63:0] pack(logic [7:0] c, s, mi, h, dy, dt, mo, y);
      return {y, mo, dt, dy, h, mi, s, c};
   endfunction

   initial begin
      #(200000 * 8);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1;
      idle(2);
      // R11: reset state
      rreg(0, "R11 ctrl", 8'h00);
      rreg(1, "R11 sec", 8'h00);
      rreg(4, "R11 day", 8'h80);
      rreg(7, "R11 year", 8'h00);
      chk("R11 load_pulse", 64'(load_pulse), 0);
      // R1: RAM path
      ram_rdata = 8'h5A; bus_sel = 1; bus_we = 0; bus_addr = 11'h123; #1;
      chk("R1 ram read", 64'(bus_rdata), 64'h5A);
      bus_addr = 11'h7F7; bus_we = 1; #1;
      chk("R1 ram write", {62'd0, ram_sel, ram_we}, 64'd3);
      cyc(); idle(1);
      // R4/R11: refresh right after reset
      cnt_vals = pack(8'hE0, 8'hD9, 8'h34, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      tick(); idle(1);
      rreg(1, "R4 sec", 8'h59);
      rreg(3, "R4 hour", 8'h23);
      rreg(0, "R10 century mask", 8'h20);
      rreg(6, "R2 month", 8'h12);
      rreg(7, "R2 year", 8'h99);
      // R5: freeze-for-read
      wreg(0, 8'h60);
      rreg(0, "R3 ctrl", 8'h60);
      cnt_vals = pack(8'h20, 8'h00, 8'h35, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      tick(); idle(1);
      rreg(1, "R5 frozen sec", 8'h59);
      // R7: tick inside settling window is ignored
      wreg(0, 8'h20);
      chk("R6 no pulse", 64'(load_pulse), 0);
      tick(); idle(1);
      rreg(1, "R7 early tick", 8'h59);
      idle(S + 2);
      tick(); idle(1);
      rreg(1, "R7 settled tick", 8'h00);
      rreg(2, "R4 min", 8'h35);
      // R6: freeze-for-set and user values
      wreg(0, 8'hA0);
      wreg(1, 8'hC5);
      chk("R9 osc_stop", 64'(osc_stop), 1);
      rreg(1, "R9 sec", 8'hC5);
      wreg(6, 8'hFF);
      rreg(6, "R10 month", 8'h1F);
      wreg(4, 8'h7F);
      batt_ok = 0;
      rreg(4, "R8 batt low", 8'h47);
      batt_ok = 1;
      rreg(4, "R8 batt ok", 8'hC7);
      chk("R9 freq_test", 64'(freq_test), 1);
      tick(); idle(1);
      rreg(1, "R6 frozen sec", 8'hC5);
      wreg(0, 8'h21);
      chk("R6 pulse", 64'(load_pulse), 1);
      chk("R6 vals", load_vals & 64'h00FF_0000_0000_FFFF, 64'h001F_0000_0000_4521);
      cyc();
      chk("R6 single", 64'(load_pulse), 0);
      // R12: write and refresh on the same edge
      idle(S + 2);
      cnt_vals = pack(8'h20, 8'h11, 8'h36, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
      tick_sec = 1;
      wreg(1, 8'h33);
      tick_sec = 0;
      rreg(1, "R12 written", 8'h33);
      rreg(2, "R12 refreshed", 8'h36);
      chk("R9 osc cleared", 64'(osc_stop), 0);
      idle(2);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule